// File: doc/BRIEF.md
# Interrupt and Reset Entry Sequencer

This block runs the entry sequence that an 8-bit processor with a 16-bit address bus performs when it leaves normal execution for a handler. There are three kinds of event: leaving reset, a non-maskable interrupt and a maskable interrupt. The execution core tells the block when it stands at an instruction boundary. At that point the block decides whether an event is due. If one is, it takes over the memory bus. It saves the return address and the status byte on the page-one stack, reads the two-byte handler address from the vector slot for that event, and hands the new program counter back to the core together with a request to set the interrupt-disable flag.

Maskable requests are level sensitive. They are gated by the interrupt-disable flag and by the core's halted indication. Non-maskable requests are caught on their rising edge and held pending until they are serviced. They win over a maskable request at the same boundary. The reset entry uses the same seven-cycle frame but suppresses its three stack writes, so the stack pointer still moves down by three.

Top module: `irq_entry_seq`

## Requirements
- R1: After reset is released the block runs a reset entry that makes no write strobe. It moves the stack pointer from 0x00 down to 0xFD, reads the handler low byte at 0xFFFC and the high byte at 0xFFFD, and presents that address on `pc_new` with `pc_load`. While reset is held, `busy` is 1 and `wr_en`, `pc_load` and `sp` are 0.
- R2: At an idle boundary with `irq_req`=1, `i_flag`=0 and `halted`=0, a maskable entry runs. It reads the handler low byte at 0xFFFE and the high byte at 0xFFFF.
- R3: A maskable request is ignored while `i_flag`=1 or `halted`=1. In that case `busy` stays 0 and `sp` does not change.
- R4: A rising edge on `nmi_req` is held pending. At the next idle boundary it is taken, whatever the values of `i_flag` and `halted`, with the low byte read at 0xFFFA and the high byte at 0xFFFB.
- R5: When a non-maskable event is pending, a maskable request at the same boundary waits. Taking the non-maskable event clears the pending state, and holding `nmi_req` high does not start another entry.
- R6: An entry writes `pc_cur[15:8]` to 0x0100+SP, then `pc_cur[7:0]` to 0x0100+SP-1, then the status byte to 0x0100+SP-2. The stack pointer decrements after each push, so it finishes three lower.
- R7: The pushed status equals `psw_cur` with bit 4 forced to 0 and bit 5 forced to 1.
- R8: `pc_load` and `set_i` are both high for exactly one cycle, seven clocks after the edge that samples the boundary. `busy` is high in between, and a boundary seen while busy starts nothing.
- R9: `rd_en` is high only during the two vector reads and never together with `wr_en`. Every write targets page 0x01.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| step_boundary | input | 1 | Core is at an instruction boundary |
| nmi_req | input | 1 | Non-maskable request, edge sensitive |
| irq_req | input | 1 | Maskable request, level sensitive |
| i_flag | input | 1 | Interrupt-disable flag of the core |
| halted | input | 1 | Core is jammed and accepts no maskable request |
| pc_cur | input | 16 | Return address to save |
| psw_cur | input | 8 | Status byte to save |
| rd_data | input | 8 | Read data, valid in the cycle `rd_en` is high |
| bus_addr | output | 16 | Bus address |
| wr_data | output | 8 | Write data |
| rd_en | output | 1 | Read strobe |
| wr_en | output | 1 | Write strobe |
| pc_new | output | 16 | Handler address |
| pc_load | output | 1 | One-cycle pulse: load `pc_new` into the PC |
| set_i | output | 1 | One-cycle pulse: set the interrupt-disable flag |
| sp | output | 8 | Stack pointer |
| busy | output | 1 | Entry sequence in progress |

## Verification
The assertions assume that memory returns `rd_data` combinationally in the same cycle as `rd_en`. They also assume that `nmi_req` is stable across each clock edge, so that an edge can be caught. The checks on gating and stack movement further assume that `i_flag`, `halted` and `irq_req` change only between edges. The stimulus drives every input on the falling clock edge. It answers reads from a small combinational vector model. It raises `nmi_req` at least one cycle before the boundary where it is expected to be taken, and during a sequence it keeps the boundary high only where the test is meant to show that the boundary is ignored.

// File: rtl/irqseq_pkg.sv
package irqseq_pkg;

  localparam int ADDR_W = 16;
  localparam int DATA_W = 8;

  // status bit positions that are forced on a push
  localparam int PSW_BRK_BIT    = 4;
  localparam int PSW_UNUSED_BIT = 5;

  // low-byte address of each handler slot; high byte sits one above
  localparam logic [ADDR_W-1:0] SLOT_NMI = 16'hFFFA;
  localparam logic [ADDR_W-1:0] SLOT_RST = 16'hFFFC;
  localparam logic [ADDR_W-1:0] SLOT_IRQ = 16'hFFFE;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LEAD,
    ST_PUSH_HI,
    ST_PUSH_LO,
    ST_PUSH_PS,
    ST_VEC_LO,
    ST_VEC_HI,
    ST_LOAD
  } seq_state_t;

  typedef enum logic [1:0] {
    EV_RESET = 2'd0,
    EV_NMI   = 2'd1,
    EV_IRQ   = 2'd2
  } ev_kind_t;

  function automatic logic [ADDR_W-1:0] slot_of(input ev_kind_t k);
    case (k)
      EV_NMI:  slot_of = SLOT_NMI;
      EV_IRQ:  slot_of = SLOT_IRQ;
      default: slot_of = SLOT_RST;
    endcase
  endfunction

endpackage

// File: rtl/irqseq_arbiter.sv
module irqseq_arbiter (
  input  logic clk,
  input  logic rst_n,
  input  logic nmi_req,
  input  logic irq_req,
  input  logic i_flag,
  input  logic halted,
  input  logic step_boundary,
  input  logic seq_idle,
  output logic take_nmi,
  output logic take_irq
);

  logic nmi_prev_q, nmi_prev_d;
  logic nmi_pend_q, nmi_pend_d;
  logic nmi_edge;
  logic at_boundary;

  always_comb begin
    nmi_edge    = nmi_req & ~nmi_prev_q;
    at_boundary = seq_idle & step_boundary;
    take_nmi    = at_boundary & nmi_pend_q;
    take_irq    = at_boundary & ~nmi_pend_q & irq_req & ~i_flag & ~halted;
    nmi_prev_d  = nmi_req;
    nmi_pend_d  = nmi_edge | (nmi_pend_q & ~take_nmi);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nmi_prev_q <= 1'b0;
      nmi_pend_q <= 1'b0;
    end else begin
      nmi_prev_q <= nmi_prev_d;
      nmi_pend_q <= nmi_pend_d;
    end
  end

  // R5: servicing drops the pending event unless a fresh edge arrived
  assert_nmi_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (take_nmi && !nmi_edge) |=> !nmi_pend_q);

  // R4: a caught edge is remembered until serviced
  assert_nmi_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (nmi_pend_q && !take_nmi) |=> nmi_pend_q);

endmodule

// File: rtl/irqseq_stack.sv
module irqseq_stack #(
  parameter logic [7:0] STACK_PAGE = 8'h01,
  parameter logic [7:0] SP_INIT    = 8'h00
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        push_step,
  output logic [7:0]  sp,
  output logic [15:0] stack_addr
);

  logic [7:0] sp_q, sp_d;

  always_comb begin
    sp_d = sp_q;
    if (push_step) sp_d = sp_q - 8'd1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sp_q <= SP_INIT;
    else        sp_q <= sp_d;
  end

  assign sp         = sp_q;
  assign stack_addr = {STACK_PAGE, sp_q};

  // R6: the pointer only moves by one, and only on a push
  assert_sp_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    push_step |=> (sp_q == $past(sp_q) - 8'd1));
  assert_sp_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !push_step |=> $stable(sp_q));

endmodule

// File: rtl/irqseq_ctrl.sv
module irqseq_ctrl
  import irqseq_pkg::*;
#(
  parameter logic [7:0] STACK_PAGE = 8'h01
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take_nmi,
  input  logic              take_irq,
  input  logic [ADDR_W-1:0] pc_cur,
  input  logic [DATA_W-1:0] psw_cur,
  input  logic [DATA_W-1:0] rd_data,
  input  logic [ADDR_W-1:0] stack_addr,
  output logic              push_step,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              rd_en,
  output logic              wr_en,
  output logic [ADDR_W-1:0] pc_new,
  output logic              pc_load,
  output logic              set_i,
  output logic              busy,
  output logic              seq_idle,
  output ev_kind_t          ev_kind
);

  seq_state_t        state_q, state_d;
  ev_kind_t          kind_q, kind_d;
  logic [ADDR_W-1:0] pc_hold_q, pc_hold_d;
  logic [DATA_W-1:0] psw_hold_q, psw_hold_d;
  logic [DATA_W-1:0] vec_lo_q, vec_lo_d;
  logic [ADDR_W-1:0] pc_new_q, pc_new_d;
  logic [DATA_W-1:0] psw_pushed;
  logic [ADDR_W-1:0] slot_base;

  // next-state process
  always_comb begin
    state_d    = state_q;
    kind_d     = kind_q;
    pc_hold_d  = pc_hold_q;
    psw_hold_d = psw_hold_q;
    vec_lo_d   = vec_lo_q;
    pc_new_d   = pc_new_q;
    case (state_q)
      ST_IDLE: begin
        if (take_nmi || take_irq) begin
          state_d    = ST_LEAD;
          kind_d     = take_nmi ? EV_NMI : EV_IRQ;
          pc_hold_d  = pc_cur;
          psw_hold_d = psw_cur;
        end
      end
      ST_LEAD:    state_d = ST_PUSH_HI;
      ST_PUSH_HI: state_d = ST_PUSH_LO;
      ST_PUSH_LO: state_d = ST_PUSH_PS;
      ST_PUSH_PS: state_d = ST_VEC_LO;
      ST_VEC_LO: begin
        state_d  = ST_VEC_HI;
        vec_lo_d = rd_data;
      end
      ST_VEC_HI: begin
        state_d  = ST_LOAD;
        pc_new_d = {rd_data, vec_lo_q};
      end
      ST_LOAD:    state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_LEAD;
      kind_q     <= EV_RESET;
      pc_hold_q  <= '0;
      psw_hold_q <= '0;
      vec_lo_q   <= '0;
      pc_new_q   <= '0;
    end else begin
      state_q    <= state_d;
      kind_q     <= kind_d;
      pc_hold_q  <= pc_hold_d;
      psw_hold_q <= psw_hold_d;
      vec_lo_q   <= vec_lo_d;
      pc_new_q   <= pc_new_d;
    end
  end

  // bus drive
  always_comb begin
    psw_pushed                 = psw_hold_q;
    psw_pushed[PSW_BRK_BIT]    = 1'b0;
    psw_pushed[PSW_UNUSED_BIT] = 1'b1;
    slot_base                  = slot_of(kind_q);

    push_step = (state_q == ST_PUSH_HI) || (state_q == ST_PUSH_LO) ||
                (state_q == ST_PUSH_PS);
    wr_en     = push_step && (kind_q != EV_RESET);
    rd_en     = (state_q == ST_VEC_LO) || (state_q == ST_VEC_HI);

    bus_addr = '0;
    wr_data  = '0;
    case (state_q)
      ST_PUSH_HI: begin bus_addr = stack_addr; wr_data = pc_hold_q[15:8]; end
      ST_PUSH_LO: begin bus_addr = stack_addr; wr_data = pc_hold_q[7:0];  end
      ST_PUSH_PS: begin bus_addr = stack_addr; wr_data = psw_pushed;      end
      ST_VEC_LO:  bus_addr = slot_base;
      ST_VEC_HI:  bus_addr = slot_base | 16'h0001;
      default: ;
    endcase
  end

  assign pc_new   = pc_new_q;
  assign pc_load  = (state_q == ST_LOAD);
  assign set_i    = (state_q == ST_LOAD);
  assign busy     = (state_q != ST_IDLE);
  assign seq_idle = (state_q == ST_IDLE);
  assign ev_kind  = kind_q;

  assert_strobe_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_en && wr_en));
  assert_wr_page_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (bus_addr[15:8] == STACK_PAGE));
  assert_rd_slot_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> (bus_addr[15:3] == 13'h1FFF));
  assert_reset_silent_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (kind_q == EV_RESET) |-> !wr_en);
  assert_load_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pc_load |=> (!pc_load && !busy));
  assert_psw_push_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && $past(wr_en) && $past(wr_en, 2)) |->
      (wr_data[PSW_UNUSED_BIT] && !wr_data[PSW_BRK_BIT]));

endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
  import irqseq_pkg::*;
#(
  parameter logic [7:0] STACK_PAGE  = 8'h01,
  parameter logic [7:0] SP_INIT     = 8'h00,
  parameter int         SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        step_boundary,
  input  logic        nmi_req,
  input  logic        irq_req,
  input  logic        i_flag,
  input  logic        halted,
  input  logic [15:0] pc_cur,
  input  logic [7:0]  psw_cur,
  input  logic [7:0]  rd_data,
  output logic [15:0] bus_addr,
  output logic [7:0]  wr_data,
  output logic        rd_en,
  output logic        wr_en,
  output logic [15:0] pc_new,
  output logic        pc_load,
  output logic        set_i,
  output logic [7:0]  sp,
  output logic        busy
);

  localparam int SYNC_MSB = SYNC_STAGES - 1;

  // reset: asserted at once, released on the clock
  logic [SYNC_MSB:0] rst_sync_q;
  logic              rst_ni;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[SYNC_MSB-1:0], 1'b1};
  end
  assign rst_ni = rst_sync_q[SYNC_MSB];

  logic              take_nmi, take_irq, seq_idle, push_step;
  logic [ADDR_W-1:0] stack_addr;
  ev_kind_t          ev_kind;

  irqseq_arbiter u_arb (
    .clk           (clk),
    .rst_n         (rst_ni),
    .nmi_req       (nmi_req),
    .irq_req       (irq_req),
    .i_flag        (i_flag),
    .halted        (halted),
    .step_boundary (step_boundary),
    .seq_idle      (seq_idle),
    .take_nmi      (take_nmi),
    .take_irq      (take_irq)
  );

  irqseq_stack #(
    .STACK_PAGE (STACK_PAGE),
    .SP_INIT    (SP_INIT)
  ) u_stack (
    .clk        (clk),
    .rst_n      (rst_ni),
    .push_step  (push_step),
    .sp         (sp),
    .stack_addr (stack_addr)
  );

  irqseq_ctrl #(
    .STACK_PAGE (STACK_PAGE)
  ) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_ni),
    .take_nmi   (take_nmi),
    .take_irq   (take_irq),
    .pc_cur     (pc_cur),
    .psw_cur    (psw_cur),
    .rd_data    (rd_data),
    .stack_addr (stack_addr),
    .push_step  (push_step),
    .bus_addr   (bus_addr),
    .wr_data    (wr_data),
    .rd_en      (rd_en),
    .wr_en      (wr_en),
    .pc_new     (pc_new),
    .pc_load    (pc_load),
    .set_i      (set_i),
    .busy       (busy),
    .seq_idle   (seq_idle),
    .ev_kind    (ev_kind)
  );

  // R3: a maskable entry only starts from an unmasked, running core
  assert_irq_gate_R3: assert property (@(posedge clk) disable iff (!rst_ni)
    ($rose(busy) && ev_kind == EV_IRQ) |-> $past(!i_flag && !halted));

  // R6: across a whole entry the pointer lands three below its start
  assert_sp_net_R6: assert property (@(posedge clk) disable iff (!rst_ni)
    pc_load |-> (sp == $past(sp, 6) - 8'd3));

  // R8: a new entry only starts on a sampled boundary
  assert_start_boundary_R8: assert property (@(posedge clk) disable iff (!rst_ni)
    $rose(busy) |-> $past(step_boundary));

endmodule

// File: tb/tb_irq_entry_seq.sv
module tb_irq_entry_seq;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        step_boundary, nmi_req, irq_req, i_flag, halted;
  logic [15:0] pc_cur;
  logic [7:0]  psw_cur, rd_data;
  logic [15:0] bus_addr, pc_new;
  logic [7:0]  wr_data, sp;
  logic        rd_en, wr_en, pc_load, set_i, busy;

  int checks = 0;
  int errors = 0;

  // captured per entry
  int          lat, nwr;
  logic [15:0] wa [3];
  logic [7:0]  wd [3];
  logic        seti_seen, clash;
  logic [15:0] pcv;

  always #4 clk = ~clk;

  irq_entry_seq dut (
    .clk(clk), .rst_n(rst_n), .step_boundary(step_boundary),
    .nmi_req(nmi_req), .irq_req(irq_req), .i_flag(i_flag), .halted(halted),
    .pc_cur(pc_cur), .psw_cur(psw_cur), .rd_data(rd_data),
    .bus_addr(bus_addr), .wr_data(wr_data), .rd_en(rd_en), .wr_en(wr_en),
    .pc_new(pc_new), .pc_load(pc_load), .set_i(set_i), .sp(sp), .busy(busy)
  );

  // combinational handler table
  always_comb begin
    rd_data = 8'h00;
    if (rd_en) begin
      case (bus_addr)
        16'hFFFA: rd_data = 8'h34;
        16'hFFFB: rd_data = 8'h12;
        16'hFFFC: rd_data = 8'h00;
        16'hFFFD: rd_data = 8'hC0;
        16'hFFFE: rd_data = 8'h78;
        16'hFFFF: rd_data = 8'h56;
        default:  rd_data = 8'hEE;
      endcase
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // starts on a falling edge; raises the boundary and follows the entry
  task automatic run_entry(input bit hold_boundary);
    nwr = 0; lat = 0; seti_seen = 0; clash = 0; pcv = '0;
    step_boundary = 1'b1;
    for (int c = 1; c <= 12; c++) begin
      @(negedge clk);
      if (!hold_boundary) step_boundary = 1'b0;
      if (rd_en && wr_en) clash = 1'b1;
      if (wr_en) begin
        if (nwr < 3) begin wa[nwr] = bus_addr; wd[nwr] = wr_data; end
        nwr++;
      end
      if (pc_load) begin
        lat = c; seti_seen = set_i; pcv = pc_new;
        step_boundary = 1'b0;
        break;
      end
    end
    @(negedge clk);
  endtask

  task automatic check_pushes(input string req, input logic [7:0] sp0,
                              input logic [15:0] pc, input logic [7:0] ps);
    chk({req, " R6 write count"}, nwr, 3);
    chk({req, " R6 PC high addr"}, wa[0], {8'h01, sp0});
    chk({req, " R6 PC high data"}, wd[0], pc[15:8]);
    chk({req, " R6 PC low addr"}, wa[1], {8'h01, sp0 - 8'd1});
    chk({req, " R6 PC low data"}, wd[1], pc[7:0]);
    chk({req, " R6 status addr"}, wa[2], {8'h01, sp0 - 8'd2});
    chk({req, " R7 status data"}, wd[2], (ps & 8'hEF) | 8'h20);
    chk({req, " R6 final sp"}, sp, sp0 - 8'd3);
    chk({req, " R8 latency"}, lat, 7);
    chk({req, " R8 set_i with load"}, seti_seen, 1'b1);
    chk({req, " R9 no strobe clash"}, clash, 1'b0);
    chk({req, " R8 idle after load"}, busy, 1'b0);
  endtask

  task automatic test_reset();
    int writes = 0;
    logic [15:0] got = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 busy in reset", busy, 1'b1);
    chk("R1 wr_en in reset", wr_en, 1'b0);
    chk("R1 pc_load in reset", pc_load, 1'b0);
    chk("R1 sp in reset", sp, 8'h00);
    rst_n = 1'b1;
    for (int c = 0; c < 20; c++) begin
      @(negedge clk);
      if (wr_en) writes++;
      if (pc_load) begin got = pc_new; break; end
    end
    @(negedge clk);
    chk("R1 no writes", writes, 0);
    chk("R1 reset vector", got, 16'hC000);
    chk("R1 sp after reset", sp, 8'hFD);
    chk("R1 idle after reset", busy, 1'b0);
  endtask

  task automatic test_irq();
    pc_cur = 16'hABCD; psw_cur = 8'hD1;
    irq_req = 1'b1; i_flag = 1'b0; halted = 1'b0;
    run_entry(1'b1);  // boundary held high while busy: R8
    irq_req = 1'b0;
    chk("R2 irq vector", pcv, 16'h5678);
    check_pushes("R2", 8'hFD, 16'hABCD, 8'hD1);
  endtask

  task automatic test_masked();
    logic seen = 1'b0;
    irq_req = 1'b1; i_flag = 1'b1; halted = 1'b0; step_boundary = 1'b1;
    for (int c = 0; c < 4; c++) begin @(negedge clk); if (busy) seen = 1'b1; end
    chk("R3 masked by i_flag", seen, 1'b0);
    chk("R3 sp unchanged i_flag", sp, 8'hFA);
    i_flag = 1'b0; halted = 1'b1;
    for (int c = 0; c < 4; c++) begin @(negedge clk); if (busy) seen = 1'b1; end
    chk("R3 masked by halted", seen, 1'b0);
    chk("R3 sp unchanged halted", sp, 8'hFA);
    step_boundary = 1'b0; irq_req = 1'b0; halted = 1'b0;
    @(negedge clk);
  endtask

  task automatic test_nmi_masked_core();
    pc_cur = 16'h0207; psw_cur = 8'h24;
    i_flag = 1'b1; halted = 1'b1;
    nmi_req = 1'b1;
    @(negedge clk);
    run_entry(1'b0);
    chk("R4 nmi vector", pcv, 16'h1234);
    check_pushes("R4", 8'hFA, 16'h0207, 8'h24);
    nmi_req = 1'b0; i_flag = 1'b0; halted = 1'b0;
    @(negedge clk);
  endtask

  task automatic test_priority();
    pc_cur = 16'h8001; psw_cur = 8'h13;
    irq_req = 1'b1; nmi_req = 1'b1;
    @(negedge clk);
    run_entry(1'b0);
    chk("R5 nmi wins", pcv, 16'h1234);
    check_pushes("R5", 8'hF7, 16'h8001, 8'h13);
    // nmi_req still high, irq still asserted: must now take the maskable one
    pc_cur = 16'h9002; psw_cur = 8'h00;
    run_entry(1'b0);
    chk("R5 pending cleared, irq next", pcv, 16'h5678);
    check_pushes("R5 follow", 8'hF4, 16'h9002, 8'h00);
    irq_req = 1'b0; nmi_req = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    #1_000_000;
    checks++; errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; step_boundary = 1'b0; nmi_req = 1'b0; irq_req = 1'b0;
    i_flag = 1'b0; halted = 1'b0; pc_cur = '0; psw_cur = '0;
    @(negedge clk);
    test_reset();
    test_irq();
    test_masked();
    test_nmi_masked_core();
    test_priority();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule